// File: doc/BRIEF.md
# Reloadable Edge Event Counter

The block counts transitions of an external event signal with a 16-bit counter. Software writes a reload value, picks which edge of the event signal is counted, and chooses where the count direction comes from. The direction is either a software bit or the level of an external direction pin. When the counter passes its terminal value, it reloads itself and raises a one-cycle interrupt request. The terminal value is zero when counting down and all-ones when counting up. An optional pulse output toggles on every such wrap, which turns the counter into a programmable event divider.

The event and direction inputs are asynchronous to the system clock. Both go through a two-flop synchronizer, and edges are detected in the system clock domain. The direction affects the division ratio: counting down from reload value n gives one wrap every n+1 counted edges, and counting up gives one wrap every 0xFFFF-n+1 counted edges.

Top module: `ectr_top`

## Requirements
- R1: After a synchronous reset, count_o is 0x0000, irq_o and pulse_o are 0, the reload register is 0x0000 and the counter is stopped.
- R2: With cfg_edge_rise=0, only falling edges of evt_i are counted; rising edges leave count_o unchanged.
- R3: With cfg_edge_rise=1, only rising edges of evt_i are counted; falling edges leave count_o unchanged.
- R4: With cfg_dir_pin=0, cfg_sw_up=0 selects down-counting (count_o decreases by 1 per counted edge).
- R5: With cfg_dir_pin=0, cfg_sw_up=1 selects up-counting (count_o increases by 1 per counted edge).
- R6: With cfg_dir_pin=1, the synchronized level of dir_i sets the direction (1 = up, 0 = down), and cfg_sw_up has no effect.
- R7: Counting down, a counted edge at count 0x0000 loads the reload value n, so one wrap occurs every n+1 counted edges. With n=0, every counted edge wraps.
- R8: Counting up, a counted edge at count 0xFFFF loads n, so one wrap occurs every 0xFFFF-n+1 counted edges. With n=0xFFFF, every counted edge wraps.
- R9: Each wrap raises irq_o for exactly one clock cycle, on the cycle after the reloading edge.
- R10: With cfg_pulse_en=1, pulse_o toggles on every wrap. With cfg_pulse_en=0, pulse_o is held low.
- R11: A reload write while stopped loads both the reload register and count_o. While running, it updates only the reload register, and the new value takes effect at the next wrap.
- R12: While cfg_run=0, count_o holds its value and no edge is counted.
- R13: A level change of evt_i, driven between clock edges, shows up in count_o after the third rising clock edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Asynchronous event signal whose edges are counted |
| dir_i | input | 1 | Asynchronous direction level (1 = up) |
| cfg_we | input | 1 | Write strobe for the control fields below |
| cfg_pulse_en | input | 1 | Pulse output enable |
| cfg_edge_rise | input | 1 | 1 = count rising edges, 0 = count falling edges |
| cfg_dir_pin | input | 1 | 1 = direction from dir_i, 0 = from cfg_sw_up |
| cfg_sw_up | input | 1 | Software direction, 1 = up, 0 = down |
| cfg_run | input | 1 | 1 = counting enabled |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_val | input | 16 | Reload value n |
| count_o | output | 16 | Current count |
| irq_o | output | 1 | One-cycle wrap interrupt request |
| pulse_o | output | 1 | Toggling wrap output |

## Verification
The properties assume that reset is applied synchronously and that the write strobes are sampled as clean single-cycle levels. Within that, they hold regardless of how evt_i and dir_i move, because both inputs pass through the synchronizer before any logic reads them. The stimulus changes every input on the falling clock edge only. It also holds each event level for four clock cycles, which is longer than the synchronizer and edge-detector delay, so no edge is ever lost and no two edges merge. Control fields change only while evt_i is steady, so changing the edge selection never creates a counted edge by itself.

// File: rtl/ectr_pkg.sv
package ectr_pkg;

    localparam int DEF_CNT_W   = 16;
    localparam int DEF_SYNC_N  = 2;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } ectr_dir_e;

    typedef struct packed {
        logic pulse_en;
        logic edge_rise;
        logic dir_pin;
        logic sw_up;
        logic run;
    } ectr_cfg_t;

    function automatic ectr_dir_e pick_dir(input ectr_cfg_t cfg, input logic pin_lvl);
        logic sel;
        sel = cfg.dir_pin ? pin_lvl : cfg.sw_up;
        return sel ? DIR_UP : DIR_DOWN;
    endfunction

endpackage

// File: rtl/ectr_sync.sv
module ectr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = ectr_pkg::DEF_SYNC_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ectr_edge.sv
module ectr_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic rise_sel,
    input  logic en,
    output logic tick
);
    logic prev_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
    assign tick = en & (rise_sel ? rise : fall);
endmodule

// File: rtl/ectr_core.sv
module ectr_core #(
    parameter int W = ectr_pkg::DEF_CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  ectr_pkg::ectr_dir_e dir,
    input  logic                run,
    input  logic                pulse_en,
    input  logic                reload_we,
    input  logic [W-1:0]        reload_val,
    output logic [W-1:0]        count,
    output logic [W-1:0]        reload_q,
    output logic                irq,
    output logic                pulse
);
    import ectr_pkg::*;

    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_MIN = '0;

    logic [W-1:0] cnt_q, rel_q;
    logic         irq_q, pls_q;
    logic         at_limit, wrap;

    assign at_limit = (dir == DIR_UP) ? (cnt_q == CNT_MAX) : (cnt_q == CNT_MIN);
    assign wrap     = tick & at_limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rel_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= wrap;
            if (reload_we) rel_q <= reload_val;
            if (reload_we && !run) begin
                cnt_q <= reload_val;
            end else if (tick) begin
                if (at_limit)            cnt_q <= rel_q;
                else if (dir == DIR_UP)  cnt_q <= cnt_q + 1'b1;
                else                     cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pulse_en) pls_q <= 1'b0;
        else if (wrap)        pls_q <= ~pls_q;
    end

    assign count    = cnt_q;
    assign reload_q = rel_q;
    assign irq      = irq_q;
    assign pulse    = pls_q & pulse_en;
endmodule

// File: rtl/ectr_top.sv
module ectr_top #(
    parameter int CNT_W  = ectr_pkg::DEF_CNT_W,
    parameter int SYNC_N = ectr_pkg::DEF_SYNC_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    input  logic             dir_i,
    input  logic             cfg_we,
    input  logic             cfg_pulse_en,
    input  logic             cfg_edge_rise,
    input  logic             cfg_dir_pin,
    input  logic             cfg_sw_up,
    input  logic             cfg_run,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o,
    output logic             pulse_o
);
    import ectr_pkg::*;

    localparam int SYNC_W = 2;

    ectr_cfg_t         cfg_q;
    logic [SYNC_W-1:0] sync_q;
    logic              evt_s, dir_s, tick;
    ectr_dir_e         dir;
    logic [CNT_W-1:0]  reload_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= '{pulse_en:  cfg_pulse_en,
                       edge_rise: cfg_edge_rise,
                       dir_pin:   cfg_dir_pin,
                       sw_up:     cfg_sw_up,
                       run:       cfg_run};
        end
    end

    ectr_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dir_i, evt_i}),
        .q   (sync_q)
    );

    assign evt_s = sync_q[0];
    assign dir_s = sync_q[1];
    assign dir   = pick_dir(cfg_q, dir_s);

    ectr_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .lvl      (evt_s),
        .rise_sel (cfg_q.edge_rise),
        .en       (cfg_q.run),
        .tick     (tick)
    );

    ectr_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .dir        (dir),
        .run        (cfg_q.run),
        .pulse_en   (cfg_q.pulse_en),
        .reload_we  (reload_we),
        .reload_val (reload_val),
        .count      (count_o),
        .reload_q   (reload_q),
        .irq        (irq_o),
        .pulse      (pulse_o)
    );
endmodule

// File: rtl/ectr_chk.sv
module ectr_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         run,
    input logic         pulse_en,
    input logic         reload_we,
    input logic [W-1:0] reload_val,
    input logic [W-1:0] reload_q,
    input logic [W-1:0] count,
    input logic         irq,
    input logic         pulse
);
    a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r12_frozen_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !reload_we) |=> $stable(count));

    a_r11_load_while_stopped: assert property (@(posedge clk) disable iff (rst)
        (reload_we && !run) |=> (count == $past(reload_val)));

    a_r7_wrap_takes_reload: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(reload_we)) |-> (count == reload_q));

    a_r10_pulse_toggles: assert property (@(posedge clk) disable iff (rst)
        (irq && pulse_en && $past(pulse_en)) |-> (pulse != $past(pulse)));

    a_r10_pulse_low_off: assert property (@(posedge clk) disable iff (rst)
        (!pulse_en && !$past(pulse_en)) |-> !pulse);
endmodule

bind ectr_top ectr_chk #(.W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (cfg_q.run),
    .pulse_en   (cfg_q.pulse_en),
    .reload_we  (reload_we),
    .reload_val (reload_val),
    .reload_q   (reload_q),
    .count      (count_o),
    .irq        (irq_o),
    .pulse      (pulse_o)
);

// File: tb/ectr_top_tb.sv
module ectr_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         evt_i = 1'b0, dir_i = 1'b0;
    logic         cfg_we = 1'b0, cfg_pulse_en = 1'b0, cfg_edge_rise = 1'b0;
    logic         cfg_dir_pin = 1'b0, cfg_sw_up = 1'b0, cfg_run = 1'b0;
    logic         reload_we = 1'b0;
    logic [W-1:0] reload_val = '0;
    logic [W-1:0] count_o;
    logic         irq_o, pulse_o;

    int n_chk = 0, n_bad = 0;
    int irq_hi = 0, irq_rise = 0;
    logic irq_prev = 1'b0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ectr_top u_dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .dir_i(dir_i),
        .cfg_we(cfg_we), .cfg_pulse_en(cfg_pulse_en), .cfg_edge_rise(cfg_edge_rise),
        .cfg_dir_pin(cfg_dir_pin), .cfg_sw_up(cfg_sw_up), .cfg_run(cfg_run),
        .reload_we(reload_we), .reload_val(reload_val),
        .count_o(count_o), .irq_o(irq_o), .pulse_o(pulse_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (irq_o) irq_hi++;
            if (irq_o && !irq_prev) irq_rise++;
        end
        irq_prev = irq_o;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic pe, input logic rise, input logic dp,
                       input logic up, input logic run);
        @(negedge clk);
        cfg_we = 1; cfg_pulse_en = pe; cfg_edge_rise = rise;
        cfg_dir_pin = dp; cfg_sw_up = up; cfg_run = run;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic load(input logic [W-1:0] v);
        @(negedge clk);
        reload_we = 1; reload_val = v;
        @(negedge clk);
        reload_we = 0;
    endtask

    task automatic pulse_evt(input int n);
        for (int i = 0; i < n; i++) begin
            evt_i = 1; repeat (4) @(negedge clk);
            evt_i = 0; repeat (4) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1 count", count_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 pulse", pulse_o, 0);
        pulse_evt(1);
        chk("R1 stopped", count_o, 0);
    endtask

    task automatic t_latency_fall;
        load(16'd5);
        chk("R11 stopped load", count_o, 5);
        cfg(0, 0, 0, 0, 1);
        evt_i = 1; repeat (4) @(negedge clk);
        chk("R2 rising ignored", count_o, 5);
        evt_i = 0;
        repeat (2) @(negedge clk);
        chk("R13 not before third edge", count_o, 5);
        @(negedge clk);
        chk("R13 R4 after third edge", count_o, 4);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_rise;
        cfg(0, 1, 0, 0, 1);
        evt_i = 1; repeat (4) @(negedge clk);
        chk("R3 rising counted", count_o, 3);
        evt_i = 0; repeat (4) @(negedge clk);
        chk("R3 falling ignored", count_o, 3);
    endtask

    task automatic t_down_wrap;
        int h, r;
        cfg(0, 0, 0, 0, 0);
        load(16'd2);
        cfg(0, 0, 0, 0, 1);
        h = irq_hi; r = irq_rise;
        pulse_evt(2);
        chk("R7 no wrap before n+1", irq_rise - r, 0);
        chk("R4 at zero", count_o, 0);
        pulse_evt(1);
        chk("R7 reload on underflow", count_o, 2);
        chk("R9 one irq", irq_rise - r, 1);
        chk("R9 one cycle high", irq_hi - h, 1);
        cfg(0, 0, 0, 0, 0);
        load(16'd0);
        cfg(0, 0, 0, 0, 1);
        r = irq_rise;
        pulse_evt(2);
        chk("R7 n=0 wraps each edge", irq_rise - r, 2);
        chk("R7 n=0 count", count_o, 0);
    endtask

    task automatic t_up_wrap;
        int r;
        cfg(0, 0, 0, 1, 0);
        load(16'hFFFD);
        cfg(0, 0, 0, 1, 1);
        r = irq_rise;
        pulse_evt(1);
        chk("R5 up count", count_o, 16'hFFFE);
        pulse_evt(1);
        chk("R8 no wrap yet", irq_rise - r, 0);
        pulse_evt(1);
        chk("R8 reload on overflow", count_o, 16'hFFFD);
        chk("R8 one wrap per FFFF-n+1", irq_rise - r, 1);
        cfg(0, 0, 0, 1, 0);
        load(16'hFFFF);
        cfg(0, 0, 0, 1, 1);
        r = irq_rise;
        pulse_evt(3);
        chk("R8 n=FFFF wraps each edge", irq_rise - r, 3);
    endtask

    task automatic t_pin_dir;
        cfg(0, 0, 0, 0, 0);
        load(16'd100);
        dir_i = 1;
        cfg(0, 0, 1, 0, 1);
        repeat (4) @(negedge clk);
        pulse_evt(2);
        chk("R6 pin up, sw bit ignored", count_o, 102);
        dir_i = 0;
        cfg(0, 0, 1, 1, 1);
        repeat (4) @(negedge clk);
        pulse_evt(3);
        chk("R6 pin down, sw bit ignored", count_o, 99);
    endtask

    task automatic t_pulse;
        cfg(1, 0, 0, 0, 0);
        load(16'd1);
        cfg(1, 0, 0, 0, 1);
        chk("R10 pulse start low", pulse_o, 0);
        pulse_evt(2);
        chk("R10 toggle high", pulse_o, 1);
        pulse_evt(2);
        chk("R10 toggle low", pulse_o, 0);
        pulse_evt(2);
        chk("R10 toggle high again", pulse_o, 1);
        cfg(0, 0, 0, 0, 1);
        chk("R10 disabled low", pulse_o, 0);
        pulse_evt(2);
        chk("R10 stays low on wrap", pulse_o, 0);
    endtask

    task automatic t_freeze;
        int r;
        cfg(0, 0, 0, 0, 0);
        load(16'd7);
        cfg(0, 0, 0, 0, 1);
        pulse_evt(2);
        cfg(0, 0, 0, 0, 0);
        r = irq_rise;
        pulse_evt(3);
        chk("R12 frozen count", count_o, 5);
        chk("R12 no irq", irq_rise - r, 0);
    endtask

    task automatic t_run_reload;
        load(16'd3);
        cfg(0, 0, 0, 0, 1);
        load(16'd9);
        chk("R11 running write keeps count", count_o, 3);
        pulse_evt(3);
        chk("R11 count before wrap", count_o, 0);
        pulse_evt(1);
        chk("R11 new value at wrap", count_o, 9);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_latency_fall();
        t_rise();
        t_down_wrap();
        t_up_wrap();
        t_pin_dir();
        t_pulse();
        t_freeze();
        t_run_reload();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule